// File: doc/BRIEF.md
# Flow-Status Burst Limiter and Path Router

This block keeps one small descriptor for each of 64 channels. The descriptor holds two burst-size codes and a 2-bit routing code. A scheduler elsewhere in the chip names a channel on the request port. One clock later the block answers with the largest burst, in bytes, that the channel may send next, and with a one-hot select that tells the data path where the channel's egress traffic goes. The four destinations are the main egress, the associated secondary port, capture to the processor, and discard.

The far end reports its FIFO state for every channel on a 2-bit status bus. The block samples that status at the moment of the request. A hungry report uses the hungry code, and a starving report uses the starving code. A satisfied report allows no burst at all. Each code N means (N+1)×16 bytes. Burst limits matter only for traffic routed to the main egress. Every other route gets a burst of zero.

Software reaches the descriptors through a simple word-wide register port. If software programs a starving code below the hungry code, the block raises a configuration-error level. While that error stands, the block uses the larger of the two codes as the starving limit.

Top module: `flow_burst_router`

## Requirements
- R1: After reset, every channel's descriptor reads back as 0x3FF (hungry code 0xF, starving code 0xF, route 11 = discard). After reset, grantValid, pathSel, burstBytes and cfgError are all zero.
- R2: A write with regWrEn stores regWrData bits 3:0 as the hungry code, bits 7:4 as the starving code and bits 9:8 as the route of channel regAddr. Bits 31:10 are ignored. The write is visible from the next cycle.
- R3: regRdEn returns channel regAddr's descriptor on regRdData one cycle later. Bits 3:0 hold the hungry code, bits 7:4 the starving code and bits 9:8 the route. Bits 31:10 read as zero. In any cycle that follows a cycle without regRdEn, regRdData is zero.
- R4: reqValid produces grantValid one cycle later, with exactly one pathSel bit set. Bit 0 stands for route 00 (main egress), bit 1 for 01 (secondary port), bit 2 for 10 (processor capture) and bit 3 for 11 (discard). A cycle without reqValid produces grantValid, pathSel and burstBytes all zero one cycle later.
- R5: Channel c's flow status is flowStatus[2c+1:2c]. When a main-egress channel reports 01 (hungry), burstBytes is (hungry code + 1) × 16.
- R6: When a main-egress channel reports 10 or 11 (starving), burstBytes is (max(starving code, hungry code) + 1) × 16.
- R7: When a main-egress channel reports 00 (satisfied), burstBytes is 0.
- R8: When a channel's route is not 00, burstBytes is 0 whatever its status is.
- R9: cfgError is high in each cycle after a write edge at which any channel holds a starving code below its hungry code. It goes low once every such channel has been rewritten.
- R10: A request reads the descriptor as it stood before any write in the same cycle, and reads the flow status present in the request cycle. Later changes to either do not alter that response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Descriptor write strobe |
| regRdEn | input | 1 | Descriptor read strobe |
| regAddr | input | 6 | Channel addressed by the register port |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, one cycle after regRdEn |
| flowStatus | input | 128 | 2-bit FIFO status per channel |
| reqValid | input | 1 | Lookup request strobe |
| reqChan | input | 6 | Channel being looked up |
| grantValid | output | 1 | Lookup response valid |
| burstBytes | output | 9 | Allowed burst length in bytes |
| pathSel | output | 4 | One-hot egress route |
| cfgError | output | 1 | Some channel holds starving code below hungry code |

## Verification
The lookup result (grantValid, pathSel, burstBytes) and the read data are due exactly one clock after their strobe. The error level changes one clock after the write that causes or clears it. The bench model works out all four values at each rising edge from the inputs present at that edge and from its own descriptor copy as it stood before that edge's writes. It compares them with the outputs at the following falling edge, so every check samples in the cycle the register output settles. Directed cases place a write and a request to the same channel in one cycle, and change the status right after a request. These cases confirm that old values are used.

// File: rtl/flow_burst_pkg.sv
package flow_burst_pkg;
  // Descriptor field positions (decoded by software and by the lookup)
  localparam int CODE_W    = 4;
  localparam int ROUTE_W   = 2;
  localparam int HUNGRY_LO = 0;
  localparam int STARVE_LO = 4;
  localparam int ROUTE_LO  = 8;
  localparam int USED_W    = 10;
  localparam int STAT_W    = 2;

  typedef enum logic [ROUTE_W-1:0] {
    ROUTE_MAIN    = 2'b00,
    ROUTE_SECOND  = 2'b01,
    ROUTE_CAPTURE = 2'b10,
    ROUTE_DROP    = 2'b11
  } route_e;

  typedef enum logic [STAT_W-1:0] {
    STAT_SATISFIED = 2'b00,
    STAT_HUNGRY    = 2'b01,
    STAT_STARVING  = 2'b10,
    STAT_STARVING2 = 2'b11
  } flowStat_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrStb;
    logic rdStb;
    logic lkStb;
    logic wrBad;
  } ctrlStb_t;
endpackage

// File: rtl/flow_burst_ctrl.sv
module flow_burst_ctrl
  import flow_burst_pkg::*;
#(
  parameter int NUM_CH = 64,
  parameter int DATA_W = 32,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [CH_W-1:0]   regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              reqValid,
  input  logic [CH_W-1:0]   reqChan,
  output ctrlStb_t          stb,
  output logic [CH_W-1:0]   accChan,
  output logic [CH_W-1:0]   lkChan,
  output logic [CODE_W-1:0] wrHungry,
  output logic [CODE_W-1:0] wrStarve,
  output route_e            wrRoute
);
  always_comb begin
    wrHungry  = regWrData[HUNGRY_LO +: CODE_W];
    wrStarve  = regWrData[STARVE_LO +: CODE_W];
    wrRoute   = route_e'(regWrData[ROUTE_LO +: ROUTE_W]);
    accChan   = regAddr;
    lkChan    = reqChan;
    stb.wrStb = regWrEn;
    stb.rdStb = regRdEn;
    stb.lkStb = reqValid;
    stb.wrBad = regWrEn && (wrStarve < wrHungry);
  end
endmodule

// File: rtl/flow_burst_dpath.sv
module flow_burst_dpath
  import flow_burst_pkg::*;
#(
  parameter int NUM_CH     = 64,
  parameter int DATA_W     = 32,
  parameter int UNIT_SHIFT = 4,
  localparam int CH_W      = $clog2(NUM_CH),
  localparam int BURST_W   = CODE_W + 1 + UNIT_SHIFT,
  localparam int NUM_ROUTE = 1 << ROUTE_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStb_t                 stb,
  input  logic [CH_W-1:0]          accChan,
  input  logic [CH_W-1:0]          lkChan,
  input  logic [CODE_W-1:0]        wrHungry,
  input  logic [CODE_W-1:0]        wrStarve,
  input  route_e                   wrRoute,
  input  logic [STAT_W*NUM_CH-1:0] flowStatus,
  output logic [DATA_W-1:0]        regRdData,
  output logic                     grantValid,
  output logic [BURST_W-1:0]       burstBytes,
  output logic [NUM_ROUTE-1:0]     pathSel,
  output logic                     cfgError
);
  logic [CODE_W-1:0] hungryQ [NUM_CH];
  logic [CODE_W-1:0] starveQ [NUM_CH];
  route_e            routeQ  [NUM_CH];
  logic [NUM_CH-1:0] badQ;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_desc
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        hungryQ[ch] <= '1;
        starveQ[ch] <= '1;
        routeQ[ch]  <= ROUTE_DROP;
        badQ[ch]    <= 1'b0;
      end else if (stb.wrStb && accChan == CH_W'(ch)) begin
        hungryQ[ch] <= wrHungry;
        starveQ[ch] <= wrStarve;
        routeQ[ch]  <= wrRoute;
        badQ[ch]    <= stb.wrBad;
      end
    end
  end

  assign cfgError = |badQ;

  // Register read-out
  logic [DATA_W-1:0] rdWord;
  always_comb begin
    rdWord = '0;
    rdWord[HUNGRY_LO +: CODE_W]  = hungryQ[accChan];
    rdWord[STARVE_LO +: CODE_W]  = starveQ[accChan];
    rdWord[ROUTE_LO +: ROUTE_W]  = routeQ[accChan];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regRdData <= '0;
    else       regRdData <= stb.rdStb ? rdWord : '0;
  end

  // Lookup
  logic [STAT_W-1:0]    statSel;
  logic [CODE_W-1:0]    codeSel;
  logic [CODE_W-1:0]    starveEff;
  logic [BURST_W-1:0]   burstNext;
  logic [NUM_ROUTE-1:0] pathNext;
  route_e               routeSel;

  always_comb begin
    statSel   = flowStatus[{lkChan, 1'b0} +: STAT_W];
    routeSel  = routeQ[lkChan];
    // a stored starving code below hungry falls back to the hungry code
    starveEff = badQ[lkChan] ? hungryQ[lkChan] : starveQ[lkChan];
    codeSel   = (statSel == STAT_HUNGRY) ? hungryQ[lkChan] : starveEff;
    burstNext = '0;
    if (routeSel == ROUTE_MAIN && statSel != STAT_SATISFIED)
      burstNext = (BURST_W'(codeSel) + BURST_W'(1)) << UNIT_SHIFT;
    pathNext = '0;
    pathNext[routeSel] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantValid <= 1'b0;
      burstBytes <= '0;
      pathSel    <= '0;
    end else begin
      grantValid <= stb.lkStb;
      burstBytes <= stb.lkStb ? burstNext : '0;
      pathSel    <= stb.lkStb ? pathNext : '0;
    end
  end
endmodule

// File: rtl/flow_burst_router.sv
module flow_burst_router
  import flow_burst_pkg::*;
#(
  parameter int NUM_CH     = 64,
  parameter int DATA_W     = 32,
  parameter int UNIT_SHIFT = 4,
  localparam int CH_W      = $clog2(NUM_CH),
  localparam int BURST_W   = CODE_W + 1 + UNIT_SHIFT,
  localparam int NUM_ROUTE = 1 << ROUTE_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     regWrEn,
  input  logic                     regRdEn,
  input  logic [CH_W-1:0]          regAddr,
  input  logic [DATA_W-1:0]        regWrData,
  output logic [DATA_W-1:0]        regRdData,
  input  logic [STAT_W*NUM_CH-1:0] flowStatus,
  input  logic                     reqValid,
  input  logic [CH_W-1:0]          reqChan,
  output logic                     grantValid,
  output logic [BURST_W-1:0]       burstBytes,
  output logic [NUM_ROUTE-1:0]     pathSel,
  output logic                     cfgError
);
  ctrlStb_t          stb;
  logic [CH_W-1:0]   accChan;
  logic [CH_W-1:0]   lkChan;
  logic [CODE_W-1:0] wrHungry;
  logic [CODE_W-1:0] wrStarve;
  route_e            wrRoute;

  flow_burst_ctrl #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) ctrl_i (
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .reqValid(reqValid), .reqChan(reqChan),
    .stb(stb), .accChan(accChan), .lkChan(lkChan),
    .wrHungry(wrHungry), .wrStarve(wrStarve), .wrRoute(wrRoute)
  );

  flow_burst_dpath #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .UNIT_SHIFT(UNIT_SHIFT)) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .accChan(accChan), .lkChan(lkChan),
    .wrHungry(wrHungry), .wrStarve(wrStarve), .wrRoute(wrRoute),
    .flowStatus(flowStatus), .regRdData(regRdData), .grantValid(grantValid),
    .burstBytes(burstBytes), .pathSel(pathSel), .cfgError(cfgError)
  );
endmodule

// File: rtl/flow_burst_router_chk.sv
module flow_burst_router_chk
  import flow_burst_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int BURST_W   = 9,
  parameter int UNIT_SHIFT = 4,
  parameter int NUM_ROUTE = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               regRdEn,
  input logic               reqValid,
  input logic [DATA_W-1:0]  regRdData,
  input logic               grantValid,
  input logic [BURST_W-1:0] burstBytes,
  input logic [NUM_ROUTE-1:0] pathSel
);
  // R4
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> $countones(pathSel) == 1);
  // R4
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !grantValid |-> (pathSel == '0 && burstBytes == '0));
  // R4
  req_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> grantValid);
  // R4
  noreq_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !grantValid);
  // R8
  nonmain_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && !pathSel[0]) |-> burstBytes == '0);
  // R5
  burst_unit_chk: assert property (@(posedge clk) disable iff (!rstN)
    burstBytes[UNIT_SHIFT-1:0] == '0 && burstBytes <= BURST_W'(16 << UNIT_SHIFT));
  // R3
  rd_reserved_chk: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[DATA_W-1:USED_W] == '0);
  // R3
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regRdEn |=> regRdData == '0);
endmodule

bind flow_burst_router flow_burst_router_chk #(
  .DATA_W(DATA_W), .BURST_W(BURST_W), .UNIT_SHIFT(UNIT_SHIFT), .NUM_ROUTE(NUM_ROUTE)
) chk_i (
  .clk(clk), .rstN(rstN), .regRdEn(regRdEn), .reqValid(reqValid),
  .regRdData(regRdData), .grantValid(grantValid), .burstBytes(burstBytes),
  .pathSel(pathSel)
);

// File: tb/flow_burst_router_tb_top.sv
module flow_burst_router_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         regWrEn = 1'b0, regRdEn = 1'b0;
  logic [5:0]   regAddr = '0;
  logic [31:0]  regWrData = '0;
  logic [31:0]  regRdData;
  logic [127:0] flowStatus = '0;
  logic         reqValid = 1'b0;
  logic [5:0]   reqChan = '0;
  logic         grantValid;
  logic [8:0]   burstBytes;
  logic [3:0]   pathSel;
  logic         cfgError;

  always #4 clk = ~clk; // 125 MHz

  flow_burst_router dut_i (.*);

  // reference model state
  int hM[64], sM[64], dM[64];
  int expGrant, expBurst, expPath, expRd, expErr;
  string burstTag, rdTag;
  bit modelOn = 0, phaseR1 = 0, done = 0;
  int checks = 0, fails = 0, cycles = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 64; i++) begin hM[i] = 15; sM[i] = 15; dM[i] = 3; end
      expGrant = 0; expBurst = 0; expPath = 0; expRd = 0; expErr = 0;
      burstTag = "R1"; rdTag = "R1";
    end else begin
      int c, st, lim;
      c = reqChan;
      expGrant = reqValid; expBurst = 0; expPath = 0; burstTag = "R4";
      if (reqValid) begin
        st = (flowStatus >> (2 * c)) & 3;
        expPath = 1 << dM[c];
        if (dM[c] != 0) burstTag = "R8";
        else if (st == 0) burstTag = "R7";
        else if (st == 1) begin burstTag = "R5"; expBurst = 16 * hM[c] + 16; end
        else begin
          burstTag = "R6";
          lim = (sM[c] > hM[c]) ? sM[c] : hM[c];
          expBurst = 16 * lim + 16;
        end
        if (regWrEn && regAddr == reqChan) burstTag = "R10";
      end
      rdTag = phaseR1 ? "R1" : "R3";
      expRd = regRdEn ? (dM[regAddr] * 256 + sM[regAddr] * 16 + hM[regAddr]) : 0;
      if (regWrEn) begin
        hM[regAddr] = regWrData[3:0];
        sM[regAddr] = regWrData[7:4];
        dM[regAddr] = regWrData[9:8];
      end
      expErr = 0;
      for (int i = 0; i < 64; i++) if (sM[i] < hM[i]) expErr = 1;
      modelOn = 1;
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (modelOn && rstN) begin
      check(burstTag == "R1" ? "R1" : "R4", "grantValid", grantValid, expGrant);
      check(burstTag == "R1" ? "R1" : "R4", "pathSel", pathSel, expPath);
      check(burstTag, "burstBytes", burstBytes, expBurst);
      check(rdTag, "regRdData", regRdData, expRd);
      check(expErr != 0 || cfgError ? "R9" : "R1", "cfgError", cfgError, expErr);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      fails++;
      $display("FAIL R4 watchdog actual=%0d expected<150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic idle();
    regWrEn = 0; regRdEn = 0; reqValid = 0;
  endtask

  task automatic wr(int ch, logic [31:0] d);
    @(negedge clk); idle(); regWrEn = 1; regAddr = ch[5:0]; regWrData = d;
  endtask

  task automatic rd(int ch);
    @(negedge clk); idle(); regRdEn = 1; regAddr = ch[5:0];
  endtask

  task automatic req(int ch, logic [1:0] st);
    @(negedge clk); idle(); reqValid = 1; reqChan = ch[5:0];
    flowStatus[2*ch +: 2] = st;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset contents read back
    phaseR1 = 1;
    for (int i = 0; i < 64; i++) rd(i);
    @(negedge clk); idle(); phaseR1 = 0;
    // R2 R3: write with reserved bits set, read back
    wr(5, 32'hFFFF_FC73 & 32'hFFFF_FC73);
    wr(5, 32'hABCD_0073);
    rd(5);
    // R5 R6 R7: hungry 3 -> 64, starving 7 -> 128, satisfied -> 0
    req(5, 2'b01); req(5, 2'b10); req(5, 2'b11); req(5, 2'b00);
    // R4 R8: each route
    wr(6, 32'h0000_0155); req(6, 2'b01);
    wr(6, 32'h0000_0255); req(6, 2'b10);
    wr(6, 32'h0000_0355); req(6, 2'b01);
    // R9: starving below hungry, fallback to hungry value
    wr(9, 32'h0000_0025); req(9, 2'b10); req(9, 2'b01);
    wr(9, 32'h0000_0055); req(9, 2'b10);
    // R10: write and request to one channel in the same cycle
    @(negedge clk); idle();
    regWrEn = 1; regAddr = 5; regWrData = 32'h0000_00F0;
    reqValid = 1; reqChan = 5; flowStatus[10 +: 2] = 2'b01;
    // R10: status changes right after the request
    req(5, 2'b10);
    @(negedge clk); idle(); flowStatus[10 +: 2] = 2'b00;
    req(5, 2'b01);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      regWrEn   = ($urandom % 4) == 0;
      regRdEn   = ($urandom % 3) == 0;
      regAddr   = 6'($urandom % 8);
      regWrData = $urandom;
      reqValid  = ($urandom % 2) == 0;
      reqChan   = 6'($urandom % 8);
      flowStatus = {$urandom, $urandom, $urandom, $urandom};
    end
    @(negedge clk); idle();
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule